// File: doc/BRIEF.md
# FS/GS Base Register Unit with Swap

This unit holds three 64-bit segment base registers: the FS base, the GS base and a kernel GS base. The address generator reads the current FS and GS bases from it. A register-access path can also read the kernel GS base. Three kinds of update can reach the registers:

- **Segment load.** A 32-bit base is written into FS or GS, and the upper half of that register is cleared.
- **Privileged write.** A full-width value is written into any of the three registers. The write succeeds only at privilege level 0 and only when the value is canonical.
- **Swap.** The GS base and the kernel GS base trade contents in a single cycle. This is allowed only in 64-bit mode.

A request that is rejected leaves every register as it was. It raises a one-cycle general-protection fault pulse or an invalid-operation fault pulse. The surrounding pipeline turns that pulse into an exception.

Requests are sampled on the rising clock edge. The registers and the fault outputs update on that same edge. When several requests arrive together, a fixed priority picks one of them. The others are dropped without effect.

Top module: `segbase_unit`

## Requirements
- R1: After reset, all three base outputs read zero and both fault outputs are low.
- R2: A segment load writes `seg_ld_base_i` into bits 31:0 of the selected base (`seg_ld_gs_i` 0 = FS, 1 = GS). It clears bits 63:32 of that base and leaves the other two bases unchanged.
- R3: A privileged write at privilege level 0 with a canonical value loads all 64 bits into the register chosen by `priv_wr_sel_i` (0 = FS, 1 = GS, 2 = kernel GS). Code 3 selects no register: nothing changes and no fault is raised.
- R4: A value is canonical when bits 63 down to VA_BITS-1 (47 with the default VA_BITS of 48) are all equal. A privileged write of a non-canonical value raises `gp_fault_o` and leaves all bases unchanged.
- R5: A privileged write at privilege level 1, 2 or 3 raises `gp_fault_o` and leaves all bases unchanged, even when the value is canonical.
- R6: A swap with `mode64_i` high exchanges the GS base and the kernel GS base in one cycle. The FS base is left unchanged.
- R7: A swap with `mode64_i` low raises `ud_fault_o` and leaves all bases unchanged.
- R8: Priority is privileged write, then segment load, then swap. Only the winning request takes effect, even when the winner faults. A losing request changes nothing and raises no fault.
- R9: Base outputs and faults change on the clock edge that samples the request. A fault is high for exactly that one cycle. The two faults are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_ld_i | input | 1 | Segment load request |
| seg_ld_gs_i | input | 1 | Segment load target: 0 = FS, 1 = GS |
| seg_ld_base_i | input | 32 | 32-bit base for the segment load |
| priv_wr_i | input | 1 | Privileged write request |
| priv_wr_sel_i | input | 2 | Write target: 0 = FS, 1 = GS, 2 = kernel GS, 3 = none |
| priv_wr_data_i | input | 64 | Privileged write value |
| priv_lvl_i | input | 2 | Current privilege level |
| mode64_i | input | 1 | High when running in 64-bit mode |
| swap_i | input | 1 | Request to swap GS and kernel GS |
| fs_base_o | output | 64 | Current FS base |
| gs_base_o | output | 64 | Current GS base |
| kgs_base_o | output | 64 | Current kernel GS base |
| gp_fault_o | output | 1 | General-protection fault pulse |
| ud_fault_o | output | 1 | Invalid-operation fault pulse |

## Verification
The main interaction is a privileged write and a swap arriving in the same cycle. A segment load meeting either of them is the second. The bench provokes these collisions by sweeping every combination of the three request bits, crossed with both modes, all four privilege levels and canonical and non-canonical write data.

Each outcome is judged against a bench model of the priority order. Only the winner may change a register or raise a fault, and a faulting winner must still block the requests below it. An idle cycle after every request confirms that each fault pulse lasts one cycle.

// File: rtl/segbase_pkg.sv
package segbase_pkg;
  localparam int unsigned NUM_BASES = 3;

  typedef enum logic [1:0] {
    TGT_FS   = 2'd0,
    TGT_GS   = 2'd1,
    TGT_KGS  = 2'd2,
    TGT_NONE = 2'd3
  } base_tgt_e;

  // operation that commits a register update this cycle
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_LOAD  = 2'd2,
    OP_SWAP  = 2'd3
  } base_op_e;
endpackage

// File: rtl/segbase_canon.sv
// Canonical check: value equals its sign extension from bit VA_BITS-1.
// Requires LOAD_W < VA_BITS < XLEN.
module segbase_canon #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned VA_BITS = 48
) (
  input  logic [XLEN-1:0] value_i,
  output logic            canon_o
);
  localparam int unsigned EXT_W = XLEN - VA_BITS;

  logic [XLEN-1:0] sext;

  assign sext    = {{EXT_W{value_i[VA_BITS-1]}}, value_i[VA_BITS-1:0]};
  assign canon_o = (sext == value_i);
endmodule

// File: rtl/segbase_arb.sv
module segbase_arb
  import segbase_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned LOAD_W = 32
) (
  input  logic              wr_i,
  input  base_tgt_e         wr_tgt_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic              wr_canon_i,
  input  logic [1:0]        priv_lvl_i,
  input  logic              ld_i,
  input  logic              ld_gs_i,
  input  logic [LOAD_W-1:0] ld_base_i,
  input  logic              swap_i,
  input  logic              mode64_i,
  output base_op_e          op_o,
  output base_tgt_e         tgt_o,
  output logic [XLEN-1:0]   data_o,
  output logic              gp_o,
  output logic              ud_o
);
  localparam int unsigned EXT_W = XLEN - LOAD_W;

  always_comb begin
    op_o   = OP_IDLE;
    tgt_o  = TGT_NONE;
    data_o = '0;
    gp_o   = 1'b0;
    ud_o   = 1'b0;
    if (wr_i) begin
      // write owns the cycle even when rejected
      if (wr_tgt_i != TGT_NONE) begin
        if ((priv_lvl_i != 2'd0) || !wr_canon_i) begin
          gp_o = 1'b1;
        end else begin
          op_o   = OP_WRITE;
          tgt_o  = wr_tgt_i;
          data_o = wr_data_i;
        end
      end
    end else if (ld_i) begin
      op_o   = OP_LOAD;
      tgt_o  = ld_gs_i ? TGT_GS : TGT_FS;
      data_o = {{EXT_W{1'b0}}, ld_base_i};
    end else if (swap_i) begin
      if (mode64_i) op_o = OP_SWAP;
      else          ud_o = 1'b1;
    end
  end
endmodule

// File: rtl/segbase_regs.sv
module segbase_regs
  import segbase_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  base_op_e                           op_i,
  input  base_tgt_e                          tgt_i,
  input  logic [XLEN-1:0]                    data_i,
  output logic [NUM_BASES-1:0][XLEN-1:0]     bases_o
);
  for (genvar i = 0; i < NUM_BASES; i++) begin : g_base
    // swap partner: GS <-> KGS, FS pairs with itself
    localparam int unsigned PARTNER = (i == 1) ? 2 : ((i == 2) ? 1 : i);

    logic [XLEN-1:0] q;
    logic [XLEN-1:0] d;

    always_comb begin
      d = q;
      if ((op_i == OP_WRITE || op_i == OP_LOAD) && (tgt_i == base_tgt_e'(i))) begin
        d = data_i;
      end else if (op_i == OP_SWAP) begin
        d = bases_o[PARTNER];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end

    assign bases_o[i] = q;
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_IDLE) |=> $stable(bases_o))
    else $error("idle cycle modified a base");
endmodule

// File: rtl/segbase_unit.sv
module segbase_unit
  import segbase_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned VA_BITS = 48,
  parameter int unsigned LOAD_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seg_ld_i,
  input  logic              seg_ld_gs_i,
  input  logic [LOAD_W-1:0] seg_ld_base_i,
  input  logic              priv_wr_i,
  input  logic [1:0]        priv_wr_sel_i,
  input  logic [XLEN-1:0]   priv_wr_data_i,
  input  logic [1:0]        priv_lvl_i,
  input  logic              mode64_i,
  input  logic              swap_i,
  output logic [XLEN-1:0]   fs_base_o,
  output logic [XLEN-1:0]   gs_base_o,
  output logic [XLEN-1:0]   kgs_base_o,
  output logic              gp_fault_o,
  output logic              ud_fault_o
);
  logic                           wr_canon;
  base_op_e                       op;
  base_tgt_e                      tgt;
  logic [XLEN-1:0]                data;
  logic                           gp_d, ud_d;
  logic                           gp_q, ud_q;
  logic [NUM_BASES-1:0][XLEN-1:0] bases;

  segbase_canon #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_canon (
    .value_i (priv_wr_data_i),
    .canon_o (wr_canon)
  );

  segbase_arb #(.XLEN(XLEN), .LOAD_W(LOAD_W)) u_arb (
    .wr_i       (priv_wr_i),
    .wr_tgt_i   (base_tgt_e'(priv_wr_sel_i)),
    .wr_data_i  (priv_wr_data_i),
    .wr_canon_i (wr_canon),
    .priv_lvl_i (priv_lvl_i),
    .ld_i       (seg_ld_i),
    .ld_gs_i    (seg_ld_gs_i),
    .ld_base_i  (seg_ld_base_i),
    .swap_i     (swap_i),
    .mode64_i   (mode64_i),
    .op_o       (op),
    .tgt_o      (tgt),
    .data_o     (data),
    .gp_o       (gp_d),
    .ud_o       (ud_d)
  );

  segbase_regs #(.XLEN(XLEN)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .tgt_i   (tgt),
    .data_i  (data),
    .bases_o (bases)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gp_q <= 1'b0;
      ud_q <= 1'b0;
    end else begin
      gp_q <= gp_d;
      ud_q <= ud_d;
    end
  end

  assign fs_base_o  = bases[TGT_FS];
  assign gs_base_o  = bases[TGT_GS];
  assign kgs_base_o = bases[TGT_KGS];
  assign gp_fault_o = gp_q;
  assign ud_fault_o = ud_q;

  // R2
  seg_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_ld_i && !priv_wr_i && !seg_ld_gs_i) |=>
      (fs_base_o == {{(XLEN-LOAD_W){1'b0}}, $past(seg_ld_base_i)}))
    else $error("FS segment load not zero-extended");

  // R4
  gp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gp_fault_o |-> ($stable(fs_base_o) && $stable(gs_base_o) && $stable(kgs_base_o)))
    else $error("faulting write modified a base");

  // R5
  priv_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_wr_i && priv_wr_sel_i != 2'd3 && priv_lvl_i != 2'd0) |=> gp_fault_o)
    else $error("unprivileged write did not fault");

  // R6
  swap_xchg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && mode64_i && !priv_wr_i && !seg_ld_i) |=>
      (gs_base_o == $past(kgs_base_o) && kgs_base_o == $past(gs_base_o) && $stable(fs_base_o)))
    else $error("swap did not exchange");

  // R7
  ud_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ud_fault_o |-> ($stable(gs_base_o) && $stable(kgs_base_o) && $stable(fs_base_o)))
    else $error("rejected swap modified a base");

  // R8
  wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_wr_i |=> !ud_fault_o)
    else $error("swap fault leaked past a write");

  // R9
  fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gp_fault_o, ud_fault_o}))
    else $error("both faults high");
endmodule

// File: tb/segbase_unit_tb_top.sv
`timescale 1ns/1ps
module segbase_unit_tb_top;
  localparam int unsigned VA = 48;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        seg_ld_i = 1'b0, seg_ld_gs_i = 1'b0;
  logic [31:0] seg_ld_base_i = '0;
  logic        priv_wr_i = 1'b0;
  logic [1:0]  priv_wr_sel_i = '0;
  logic [63:0] priv_wr_data_i = '0;
  logic [1:0]  priv_lvl_i = '0;
  logic        mode64_i = 1'b0, swap_i = 1'b0;
  logic [63:0] fs_base_o, gs_base_o, kgs_base_o;
  logic        gp_fault_o, ud_fault_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_fs = '0, m_gs = '0, m_kgs = '0;
  logic        m_gp = 1'b0, m_ud = 1'b0;

  always #4 clk_i = ~clk_i;

  segbase_unit dut_i (
    .clk_i, .rst_ni, .seg_ld_i, .seg_ld_gs_i, .seg_ld_base_i,
    .priv_wr_i, .priv_wr_sel_i, .priv_wr_data_i, .priv_lvl_i,
    .mode64_i, .swap_i, .fs_base_o, .gs_base_o, .kgs_base_o,
    .gp_fault_o, .ud_fault_o
  );

  function automatic bit is_canon(logic [63:0] v);
    logic [63:0] top;
    top = v >> (VA - 1);
    return (top == 64'd0) || (top == ((64'd1 << (64 - VA + 1)) - 64'd1));
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (fs_base_o !== m_fs || gs_base_o !== m_gs || kgs_base_o !== m_kgs ||
        gp_fault_o !== m_gp || ud_fault_o !== m_ud) begin
      errors++;
      $display("FAIL %s: act fs=%h gs=%h kgs=%h gp=%b ud=%b exp fs=%h gs=%h kgs=%h gp=%b ud=%b",
               tag, fs_base_o, gs_base_o, kgs_base_o, gp_fault_o, ud_fault_o,
               m_fs, m_gs, m_kgs, m_gp, m_ud);
    end
  endtask

  task automatic step(input logic wr, input logic [1:0] wsel, input logic [63:0] wdata,
                      input logic [1:0] priv, input logic ld, input logic ldgs,
                      input logic [31:0] lbase, input logic sw, input logic m64);
    string tag;
    logic [63:0] t;
    priv_wr_i = wr; priv_wr_sel_i = wsel; priv_wr_data_i = wdata; priv_lvl_i = priv;
    seg_ld_i = ld; seg_ld_gs_i = ldgs; seg_ld_base_i = lbase;
    swap_i = sw; mode64_i = m64;
    @(posedge clk_i); #2;
    m_gp = 1'b0; m_ud = 1'b0; tag = "R9";
    if (wr) begin
      if (wsel == 2'd3)                      tag = "R3";
      else if (priv != 2'd0) begin m_gp = 1'b1; tag = "R5"; end
      else if (!is_canon(wdata)) begin m_gp = 1'b1; tag = "R4"; end
      else begin
        tag = "R3";
        case (wsel)
          2'd0: m_fs = wdata;
          2'd1: m_gs = wdata;
          default: m_kgs = wdata;
        endcase
      end
    end else if (ld) begin
      tag = "R2";
      if (ldgs) m_gs = {32'd0, lbase};
      else      m_fs = {32'd0, lbase};
    end else if (sw) begin
      if (m64) begin tag = "R6"; t = m_gs; m_gs = m_kgs; m_kgs = t; end
      else begin tag = "R7"; m_ud = 1'b1; end
    end
    if ((int'(wr) + int'(ld) + int'(sw)) > 1) tag = "R8";
    compare(tag);
    priv_wr_i = 1'b0; seg_ld_i = 1'b0; swap_i = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 2'd0, 64'd0, 2'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: act hung exp done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20; rst_ni = 1'b1; #3;
    // R1 reset state
    compare("R1");
    @(negedge clk_i);

    // R2: full-width value first, then segment load must clear the top half
    for (int k = 0; k < 32; k++) begin
      step(1'b1, {1'b0, k[0]}, 64'hffff_ffff_ffff_ffff ^ (64'd1 << k), 2'd0,
           1'b0, 1'b0, 32'd0, 1'b0, 1'b0);
      step(1'b0, 2'd0, 64'd0, 2'd0, 1'b1, k[0], 32'h8000_0001 ^ (32'd1 << k), 1'b0, 1'b0);
    end

    // R3 R4 R5: walk every bit set and clear, every target, every level
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 4; p++)
        for (int b = 0; b < 64; b++)
          for (int inv = 0; inv < 2; inv++) begin
            step(1'b1, 2'(s), (inv != 0) ? ~(64'd1 << b) : (64'd1 << b), 2'(p),
                 1'b0, 1'b0, 32'd0, 1'b0, 1'b0);
            idle();
          end

    // R6 R7: swaps in both modes over varied contents
    for (int k = 0; k < 16; k++) begin
      step(1'b1, 2'd1, 64'h0000_1234_0000_0000 + 64'(k), 2'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0);
      step(1'b1, 2'd2, 64'hffff_8000_0000_0000 + 64'(k * 3), 2'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0);
      step(1'b0, 2'd0, 64'd0, 2'd0, 1'b0, 1'b0, 32'd0, 1'b1, k[0]);
      idle();
      step(1'b0, 2'd0, 64'd0, 2'd0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b1);
    end

    // R8: every request combination crossed with mode, level and data shape
    for (int m = 0; m < 8; m++)
      for (int md = 0; md < 2; md++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 2; c++) begin
            step(m[0], 2'((m + p) % 3), (c != 0) ? 64'h0001_0000_0000_0000 + 64'(m) : 64'h0000_0abc_0000_0000 + 64'(p),
                 2'(p), m[1], md[0], 32'hc0de_0000 + 32'(m * 16 + p), m[2], md[0]);
            idle();
          end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule